// File: doc/BRIEF.md
# Cascaded Divide-and-Capture Pulse Counter

This block measures the ratio between two pulse trains. Rising edges of input A go to a reloadable down-counter that divides them by a programmable factor. Each time that divider wraps, a second counter steps up by one. Rising edges of input B go to a second reloadable divider. Each time the B divider wraps, the running count of divided A pulses is copied into a capture register. The copy is therefore the number of divided A pulses seen in one divided B period.

After each capture the running count can be zeroed, so every capture holds the count for one window. The capture can also set an interrupt flag, which software clears by writing 1. Software controls the block through a small register set. It uses a write strobe with an address and reads back through a combinational data path. Both pulse inputs may be asynchronous to the block clock.

Top module: `ratio_capture_timer`

## Requirements
- R1: Each input passes through a two-flop synchroniser and then rising-edge detection. One low-to-high transition counts as exactly one event however long the level stays high. Its effect on counters, capture and flag is registered on the third rising clock edge after the input rises.
- R2: Divider A (load register at address 2) counts down by one per A event. An A event that finds the count at zero reloads it from the load register and emits one underflow, so a load value L divides by L+1. Writing the load register also loads the counter.
- R3: The running counter steps up by one on each divider A underflow and wraps from 255 to 0. It has no reload.
- R4: Divider B (load register at address 3) works like divider A on B events. Each divider B underflow copies the running count into the capture register, which is read at address 4 and is otherwise unchanged.
- R5: When bit 7 of mode register 1 (address 0) is 1, a capture zeroes the running counter. When that bit is 0, the counter keeps counting.
- R6: A capture with bit 2 of mode register 2 (address 1) at 0 sets the interrupt flag. The flag is driven on `irq` and read as bit 0 at address 5. Writing 1 to bit 0 at address 5 clears it. Writing 0 has no effect, and a capture in the same cycle as a clear wins.
- R7: When bit 2 of mode register 2 is 1, captures still update the capture register but leave the flag unchanged.
- R8: After reset, mode register 1 reads 0x80, mode register 2 reads 0x00, both load registers and both dividers hold 0xFF, and the running counter, capture register and flag are 0.
- R9: A capture and a running-counter increment in the same cycle capture the value before the increment. If clearing is enabled, the counter then ends at 0. Writes to address 4 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_a | input | 1 | Pulse input that is divided and counted |
| in_b | input | 1 | Pulse input that sets the measurement window |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data for `addr` (combinational) |
| irq | output | 1 | Capture interrupt flag |

## Verification
A pulse input that rises just after a clock edge acts on the registers at the third clock edge after it rises: two synchroniser flops, then the counter and flag update. Register writes take effect at the next edge, and reads are combinational. The bench drives every input at a falling edge. It holds each pulse for four cycles and then leaves four low cycles before it samples, so each result has settled when it is read. One directed case samples `irq` at the falling edges that follow the second and third rising edges to confirm the three-cycle latency.

// File: rtl/rct_pkg.sv
package rct_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_MODE1 = 3'd0,
    REG_MODE2 = 3'd1,
    REG_LOAD_A = 3'd2,
    REG_LOAD_B = 3'd3,
    REG_CAPT  = 3'd4,
    REG_STAT  = 3'd5
  } reg_addr_e;

  localparam int CLR_AFTER_CAP_BIT = 7;
  localparam int IRQ_MUTE_BIT      = 2;
  localparam int STAT_FLAG_BIT     = 0;
endpackage

// File: rtl/input_edge_detect.sv
module input_edge_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise_o
);
  localparam int CHAIN = STAGES + 1;

  logic [CHAIN-1:0] chain_q;
  logic [CHAIN-1:0] chain_d;

  always_comb begin
    chain_d = chain_q;
    chain_d[0] = din;
    for (int i = 1; i < CHAIN; i++) begin
      chain_d[i] = chain_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];

  // R1
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/down_divider.sv
module down_divider #(
  parameter int W = 8,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         ld_we,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] cnt_o,
  output logic         uf_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         at_zero;

  assign at_zero = (cnt_q == '0);
  assign uf_o    = tick & at_zero;

  always_comb begin
    cnt_d = cnt_q;
    if (ld_we) begin
      cnt_d = ld_val;
    end else if (tick) begin
      if (at_zero) cnt_d = ld_val;
      else         cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= RST_VAL;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R2
  reload_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uf_o && !ld_we) |=> (cnt_o == $past(ld_val)));

  // R2
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ld_we && cnt_o != '0) |=> (cnt_o == $past(cnt_o) - 1'b1));

  // R2
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ld_we) |=> $stable(cnt_o));
endmodule

// File: rtl/event_counter_capture.sv
module event_counter_capture #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         cap_stb,
  input  logic         clr_en,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cap_o
);
  logic [W-1:0] run_q, run_d;
  logic [W-1:0] cap_q, cap_d;

  always_comb begin
    run_d = run_q;
    cap_d = cap_q;
    if (cap_stb) cap_d = run_q;
    if (cap_stb && clr_en) run_d = '0;
    else if (inc)          run_d = run_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      cap_q <= '0;
    end else begin
      run_q <= run_d;
      cap_q <= cap_d;
    end
  end

  assign cnt_o = run_q;
  assign cap_o = cap_q;

  // R4
  capture_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stb |=> (cap_o == $past(cnt_o)));

  // R4
  capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_stb |=> $stable(cap_o));

  // R5
  clear_after_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_stb && clr_en) |=> (cnt_o == '0));

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !(cap_stb && clr_en)) |=> (cnt_o == $past(cnt_o) + 1'b1));
endmodule

// File: rtl/ratio_capture_timer.sv
module ratio_capture_timer
  import rct_pkg::*;
#(
  parameter int W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_a,
  input  logic              in_b,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      rdata,
  output logic              irq
);
  localparam logic [W-1:0] MODE1_RST = W'(1) << CLR_AFTER_CAP_BIT;
  localparam logic [W-1:0] LOAD_RST  = '1;

  logic [W-1:0] mode1_q, mode1_d;
  logic [W-1:0] mode2_q, mode2_d;
  logic [W-1:0] load_a_q, load_a_d;
  logic [W-1:0] load_b_q, load_b_d;
  logic         flag_q, flag_d;

  logic         we_mode1, we_mode2, we_load_a, we_load_b, we_stat;
  logic [1:0]   rise;
  logic [1:0]   pin_vec;
  logic         uf_a, uf_b;
  logic [W-1:0] div_a_cnt, div_b_cnt;
  logic [W-1:0] run_cnt, cap_val;

  assign pin_vec = {in_b, in_a};

  for (genvar g = 0; g < 2; g++) begin : g_in
    input_edge_detect #(.STAGES(SYNC_STAGES)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .din    (pin_vec[g]),
      .rise_o (rise[g])
    );
  end

  assign we_mode1  = wr_en && (addr == REG_MODE1);
  assign we_mode2  = wr_en && (addr == REG_MODE2);
  assign we_load_a = wr_en && (addr == REG_LOAD_A);
  assign we_load_b = wr_en && (addr == REG_LOAD_B);
  assign we_stat   = wr_en && (addr == REG_STAT);

  down_divider #(.W(W), .RST_VAL(LOAD_RST)) u_div_a (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (rise[0]),
    .ld_we  (we_load_a),
    .ld_val (we_load_a ? wdata : load_a_q),
    .cnt_o  (div_a_cnt),
    .uf_o   (uf_a)
  );

  down_divider #(.W(W), .RST_VAL(LOAD_RST)) u_div_b (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (rise[1]),
    .ld_we  (we_load_b),
    .ld_val (we_load_b ? wdata : load_b_q),
    .cnt_o  (div_b_cnt),
    .uf_o   (uf_b)
  );

  event_counter_capture #(.W(W)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc     (uf_a),
    .cap_stb (uf_b),
    .clr_en  (mode1_q[CLR_AFTER_CAP_BIT]),
    .cnt_o   (run_cnt),
    .cap_o   (cap_val)
  );

  always_comb begin
    mode1_d  = mode1_q;
    mode2_d  = mode2_q;
    load_a_d = load_a_q;
    load_b_d = load_b_q;
    flag_d   = flag_q;
    if (we_mode1)  mode1_d  = wdata;
    if (we_mode2)  mode2_d  = wdata;
    if (we_load_a) load_a_d = wdata;
    if (we_load_b) load_b_d = wdata;
    if (we_stat && wdata[STAT_FLAG_BIT]) flag_d = 1'b0;
    if (uf_b && !mode2_q[IRQ_MUTE_BIT])  flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode1_q  <= MODE1_RST;
      mode2_q  <= '0;
      load_a_q <= LOAD_RST;
      load_b_q <= LOAD_RST;
      flag_q   <= 1'b0;
    end else begin
      mode1_q  <= mode1_d;
      mode2_q  <= mode2_d;
      load_a_q <= load_a_d;
      load_b_q <= load_b_d;
      flag_q   <= flag_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      REG_MODE1:  rdata = mode1_q;
      REG_MODE2:  rdata = mode2_q;
      REG_LOAD_A: rdata = load_a_q;
      REG_LOAD_B: rdata = load_b_q;
      REG_CAPT:   rdata = cap_val;
      REG_STAT:   rdata = {{(W-1){1'b0}}, flag_q};
      default:    rdata = '0;
    endcase
  end

  assign irq = flag_q;

  // R6
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uf_b && !mode2_q[IRQ_MUTE_BIT]) |=> irq);

  // R7
  irq_muted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && mode2_q[IRQ_MUTE_BIT]) |=> !irq);

  // R6
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(we_stat && wdata[STAT_FLAG_BIT])) |=> irq);
endmodule

// File: tb/ratio_capture_timer_tb.sv
`timescale 1ns/1ps
module ratio_capture_timer_tb;
  logic       clk;
  logic       rst_n;
  logic       in_a, in_b;
  logic       wr_en;
  logic [2:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;

  // bench-side model state
  logic [7:0] m_la, m_lb, m_da, m_db, m_run, m_cap;
  logic       m_clr, m_mute, m_flag;

  ratio_capture_timer u_dut (
    .clk(clk), .rst_n(rst_n), .in_a(in_a), .in_b(in_b),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (a)
      3'd0: m_clr = d[7];
      3'd1: m_mute = d[2];
      3'd2: begin m_la = d; m_da = d; end
      3'd3: begin m_lb = d; m_db = d; end
      3'd5: if (d[0]) m_flag = 1'b0;
      default: ;
    endcase
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  function automatic void model_edge(input bit a, input bit b);
    bit capf = 0;
    bit incf = 0;
    if (b) begin
      if (m_db == 8'd0) begin m_db = m_lb; capf = 1; end
      else m_db = m_db - 8'd1;
    end
    if (a) begin
      if (m_da == 8'd0) begin m_da = m_la; incf = 1; end
      else m_da = m_da - 8'd1;
    end
    if (capf) m_cap = m_run;
    if (capf && m_clr) m_run = 8'd0;
    else if (incf) m_run = m_run + 8'd1;
    if (capf && !m_mute) m_flag = 1'b1;
  endfunction

  task automatic pulse(input bit a, input bit b, input int hold);
    @(negedge clk);
    in_a = a; in_b = b;
    repeat (hold) @(negedge clk);
    in_a = 1'b0; in_b = 1'b0;
    repeat (4) @(negedge clk);
    model_edge(a, b);
  endtask

  task automatic check_outputs(input string req);
    logic [7:0] v;
    rd(3'd4, v); chk({req, " capture"}, v, m_cap);
    rd(3'd5, v); chk({req, " status"}, v, {7'd0, m_flag});
    chk({req, " irq pin"}, {7'd0, irq}, {7'd0, m_flag});
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int unsigned r;
    r = $urandom(32'd20240611);
    in_a = 0; in_b = 0; wr_en = 0; addr = 0; wdata = 0;
    rst_n = 0;
    m_la = 8'hFF; m_lb = 8'hFF; m_da = 8'hFF; m_db = 8'hFF;
    m_run = 0; m_cap = 0; m_clr = 1; m_mute = 0; m_flag = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R8 reset state
    rd(3'd0, v); chk("R8 mode1", v, 8'h80);
    rd(3'd1, v); chk("R8 mode2", v, 8'h00);
    rd(3'd2, v); chk("R8 load A", v, 8'hFF);
    rd(3'd3, v); chk("R8 load B", v, 8'hFF);
    check_outputs("R8");

    // R2 R3 R4 R5: divide A by 3, B by 2
    wr(3'd2, 8'd2);
    wr(3'd3, 8'd1);
    for (int i = 0; i < 7; i++) pulse(1, 0, 4);
    pulse(0, 1, 4);
    check_outputs("R4 no capture before B wrap");
    pulse(0, 1, 4);
    chk("R2 R4 captured count", m_cap, 8'd2);
    check_outputs("R4 R2 first window");
    for (int i = 0; i < 3; i++) pulse(1, 0, 4);
    pulse(0, 1, 4); pulse(0, 1, 4);
    check_outputs("R5 cleared window");

    // R6 write 0 leaves flag; write 1 clears
    wr(3'd5, 8'h00);
    check_outputs("R6 write zero ignored");
    wr(3'd5, 8'h01);
    check_outputs("R6 write one clears");

    // R1 long high level counts once; timing of flag
    wr(3'd2, 8'd0);
    wr(3'd3, 8'd0);
    pulse(1, 0, 40);
    @(negedge clk);
    in_b = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1 irq not yet after two edges", {7'd0, irq}, 8'd0);
    @(negedge clk);
    chk("R1 irq after three edges", {7'd0, irq}, 8'd1);
    repeat (3) @(negedge clk);
    in_b = 1'b0;
    repeat (4) @(negedge clk);
    model_edge(0, 1);
    chk("R1 long level single count", m_cap, 8'd1);
    check_outputs("R1");
    wr(3'd5, 8'h01);

    // R5 clear disabled: counts accumulate
    wr(3'd0, 8'h00);
    pulse(1, 0, 4); pulse(1, 0, 4); pulse(0, 1, 4);
    pulse(1, 0, 4); pulse(0, 1, 4);
    chk("R5 accumulating model", m_cap, 8'd3);
    check_outputs("R5 no clear");

    // R7 muted interrupt
    wr(3'd5, 8'h01);
    wr(3'd1, 8'h04);
    pulse(1, 0, 4); pulse(0, 1, 4);
    check_outputs("R7 muted capture");

    // R9 simultaneous edges, clear enabled and disabled
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h80);
    pulse(1, 0, 4);
    pulse(1, 1, 4);
    check_outputs("R9 simultaneous clear");
    pulse(0, 1, 4);
    chk("R9 run cleared despite increment", m_cap, 8'd0);
    check_outputs("R9 after simultaneous");
    wr(3'd0, 8'h00);
    pulse(1, 1, 4); pulse(0, 1, 4);
    check_outputs("R9 simultaneous no clear");

    // R9 capture address not writable
    wr(3'd4, 8'h5A);
    check_outputs("R9 capture write ignored");

    // R3 wrap: count 260 undivided A pulses, no clear
    wr(3'd5, 8'h01);
    for (int i = 0; i < 260; i++) pulse(1, 0, 1);
    pulse(0, 1, 4);
    check_outputs("R3 wrap");

    // random mix
    wr(3'd0, 8'h80);
    for (int i = 0; i < 400; i++) begin
      r = $urandom_range(0, 19);
      if (r < 10)       pulse(1, 0, 1 + int'($urandom_range(0, 3)));
      else if (r < 14)  begin pulse(0, 1, 2); check_outputs("R4 R5 random"); end
      else if (r == 14) pulse(1, 1, 2);
      else if (r == 15) wr(3'd2, 8'($urandom_range(0, 3)));
      else if (r == 16) wr(3'd3, 8'($urandom_range(0, 3)));
      else if (r == 17) wr(3'd0, ($urandom_range(0, 1) != 0) ? 8'h80 : 8'h00);
      else if (r == 18) wr(3'd1, ($urandom_range(0, 3) == 0) ? 8'h04 : 8'h00);
      else              wr(3'd5, 8'($urandom_range(0, 1)));
    end
    check_outputs("R6 R7 random end");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule